// File: doc/BRIEF.md
# Multi-Core Timebase Counters with Shared Control

This block holds one free-running 64-bit timebase counter per processor core. Every counter advances by one on each clock. Software may overwrite either 32-bit half of any core's counter through a narrow write port. A read port returns a counter value one cycle after the request. When reads are restricted, that response can instead carry a privilege fault.

A small control register, reached over a simple register bus, is shared by all cores. One bit stops every counter at the same time, which lets software load all of them and then release them together so that they stay aligned. The other bit limits timebase reads to privileged mode in every core. The counters are cleared only by the system reset. The block exports the current count enable so that neighbouring logic can see whether time is frozen.

Top module: `tbase_cluster`

## Requirements
- R1: While `sysRst` is high at a clock edge, every counter and both control bits become zero. Afterwards `countEn` reads 1, `regRdata` reads 0 and `rdValid` is 0.
- R2: When `countEn` is 1 and no write targets a core, that core's counter increases by exactly one at each clock edge. Each core's counter is independent of every other core's.
- R3: A write with `wrHigh`=0 replaces bits 31:0 of the core selected by `wrCore` with `wrData` and keeps bits 63:32. That core is not incremented at that edge.
- R4: A write with `wrHigh`=1 replaces bits 63:32 of the selected core with `wrData` and keeps bits 31:0. That core is not incremented at that edge.
- R5: An increment carries out of bit 31 into bit 32. The counter wraps from all ones to zero.
- R6: A write on the register bus (`regWr`=1) loads bit 0 (freeze) and bit 1 (read restriction) from `regWdata`. `regRdata` returns the two bits in those positions, and bits above 1 read zero. The new value takes effect from the next cycle.
- R7: While the freeze bit is 1, `countEn` is 0 and every counter holds its value. Half writes still apply. Clearing the bit resumes counting.
- R8: While the read-restriction bit is 1, a read with `rdPriv`=0 returns `rdData`=0 with `rdFault`=1 for one cycle, alongside `rdValid`. A read with `rdPriv`=1 succeeds. With the bit at 0, reads at either privilege level succeed with `rdFault`=0.
- R9: A request (`rdReq`=1) sampled at an edge produces `rdValid`=1 in the following cycle. `rdData` then carries the value the selected counter held just before that edge. With no request, `rdValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRst | input | 1 | System reset, synchronous, active high |
| countEn | output | 1 | High when counters advance (freeze bit clear) |
| wrEn | input | 1 | Half-write request |
| wrCore | input | IDX_W | Target core of a half write |
| wrHigh | input | 1 | 1 selects bits 63:32, 0 selects bits 31:0 |
| wrData | input | HALF_W | Data for the selected half |
| rdReq | input | 1 | Read request |
| rdCore | input | IDX_W | Core whose counter is read |
| rdPriv | input | 1 | 1 when the reader is privileged |
| rdValid | output | 1 | Read response valid |
| rdData | output | 2*HALF_W | Read data, zero on a refused read |
| rdFault | output | 1 | Privilege fault pulse with the response |
| regWr | input | 1 | Control register write strobe |
| regWdata | input | REG_W | Control register write data |
| regRdata | output | REG_W | Control register read data |

## Verification
The assertions take for granted that `wrCore` and `rdCore` name an existing core and that each cycle carries at most one half write. The block then needs only one write strobe per core.

The stimulus draws core indices modulo the core count and issues at most one write per cycle. It biases write data toward values near all ones, so that carries into the upper half and the full wrap happen often. Directed cases exercise:
- writes that land on an increment edge;
- writes made while the counters are frozen;
- user and privileged reads on both sides of the restriction bit.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int HALF_W_DEF = 32;

  // per-core strobes from control to the counter datapath
  typedef struct packed {
    logic incr;
    logic wrLo;
    logic wrHi;
  } tbStrobe_t;
endpackage

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2,
  parameter int REG_W     = 32
) (
  input  logic                            clk,
  input  logic                            sysRst,
  input  logic                            regWr,
  input  logic [REG_W-1:0]                regWdata,
  output logic [REG_W-1:0]                regRdata,
  input  logic                            wrEn,
  input  logic [IDX_W-1:0]                wrCore,
  input  logic                            wrHigh,
  output logic                            countEn,
  output logic                            privOnly,
  output tbStrobe_t [NUM_CORES-1:0]       strobes
);
  localparam int FREEZE_BIT = 0;
  localparam int PRIV_BIT   = 1;

  logic freezeQ;
  logic privQ;

  always_ff @(posedge clk) begin
    if (sysRst) begin
      freezeQ <= 1'b0;
      privQ   <= 1'b0;
    end else if (regWr) begin
      freezeQ <= regWdata[FREEZE_BIT];
      privQ   <= regWdata[PRIV_BIT];
    end
  end

  always_comb begin
    regRdata             = '0;
    regRdata[FREEZE_BIT] = freezeQ;
    regRdata[PRIV_BIT]   = privQ;
  end

  assign countEn  = ~freezeQ;
  assign privOnly = privQ;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_strobe
    logic hit;
    assign hit             = wrEn && (wrCore == IDX_W'(i));
    assign strobes[i].wrLo = hit && !wrHigh;
    assign strobes[i].wrHi = hit && wrHigh;
    assign strobes[i].incr = ~freezeQ;
  end

  // R6: a bus write shows up in the read-back one cycle later
  p_ctrl_write_r6: assert property (@(posedge clk) disable iff (sysRst)
    regWr |=> (regRdata[1:0] == $past(regWdata[1:0])));

  // R7: the freeze bit alone gates counting
  p_freeze_gate_r7: assert property (@(posedge clk) disable iff (sysRst)
    (regWr && regWdata[FREEZE_BIT]) |=> !countEn);
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter
  import tbc_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int TB_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              sysRst,
  input  tbStrobe_t         strobe,
  input  logic [HALF_W-1:0] wrData,
  output logic [TB_W-1:0]   value
);
  logic [HALF_W-1:0] loQ;
  logic [HALF_W-1:0] hiQ;
  logic              loCarry;

  assign loCarry = &loQ;

  always_ff @(posedge clk) begin
    if (sysRst) begin
      loQ <= '0;
      hiQ <= '0;
    end else if (strobe.wrLo) begin
      loQ <= wrData;
    end else if (strobe.wrHi) begin
      hiQ <= wrData;
    end else if (strobe.incr) begin
      loQ <= loQ + 1'b1;
      hiQ <= hiQ + HALF_W'(loCarry);
    end
  end

  assign value = {hiQ, loQ};

  p_lo_write_r3: assert property (@(posedge clk) disable iff (sysRst)
    strobe.wrLo |=> (value[HALF_W-1:0] == $past(wrData)) &&
                    (value[TB_W-1:HALF_W] == $past(value[TB_W-1:HALF_W])));

  p_hi_write_r4: assert property (@(posedge clk) disable iff (sysRst)
    strobe.wrHi |=> (value[TB_W-1:HALF_W] == $past(wrData)) &&
                    (value[HALF_W-1:0] == $past(value[HALF_W-1:0])));

  p_hold_r7: assert property (@(posedge clk) disable iff (sysRst)
    (!strobe.incr && !strobe.wrLo && !strobe.wrHi) |=> $stable(value));

  p_wrap_r5: assert property (@(posedge clk) disable iff (sysRst)
    (strobe.incr && !strobe.wrLo && !strobe.wrHi && (&value)) |=> (value == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (sysRst)
    (strobe.incr && !strobe.wrLo && !strobe.wrHi) |=> (value == $past(value) + 1'b1));
endmodule

// File: rtl/tbc_readport.sv
module tbc_readport #(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 2,
  parameter int TB_W      = 64
) (
  input  logic                            clk,
  input  logic                            sysRst,
  input  logic                            rdReq,
  input  logic [IDX_W-1:0]                rdCore,
  input  logic                            rdPriv,
  input  logic                            privOnly,
  input  logic [NUM_CORES-1:0][TB_W-1:0]  values,
  output logic                            rdValid,
  output logic [TB_W-1:0]                 rdData,
  output logic                            rdFault
);
  logic [TB_W-1:0] selVal;
  logic            deny;

  always_comb begin
    selVal = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (rdCore == IDX_W'(i)) selVal = values[i];
    end
  end

  assign deny = privOnly && !rdPriv;

  always_ff @(posedge clk) begin
    if (sysRst) begin
      rdValid <= 1'b0;
      rdFault <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdReq;
      rdFault <= rdReq && deny;
      rdData  <= (rdReq && !deny) ? selVal : '0;
    end
  end

  p_fault_data_r8: assert property (@(posedge clk) disable iff (sysRst)
    rdFault |-> (rdValid && (rdData == '0)));

  p_fault_cause_r8: assert property (@(posedge clk) disable iff (sysRst)
    rdFault |-> $past(privOnly && !rdPriv));

  p_valid_r9: assert property (@(posedge clk) disable iff (sysRst)
    rdValid |-> $past(rdReq));
endmodule

// File: rtl/tbase_cluster.sv
module tbase_cluster
  import tbc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int HALF_W    = HALF_W_DEF,
  parameter int REG_W     = 32,
  localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int TB_W     = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              sysRst,
  output logic              countEn,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrCore,
  input  logic              wrHigh,
  input  logic [HALF_W-1:0] wrData,
  input  logic              rdReq,
  input  logic [IDX_W-1:0]  rdCore,
  input  logic              rdPriv,
  output logic              rdValid,
  output logic [TB_W-1:0]   rdData,
  output logic              rdFault,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata
);
  tbStrobe_t [NUM_CORES-1:0]      strobes;
  logic [NUM_CORES-1:0][TB_W-1:0] values;
  logic                           privOnly;

  tbc_ctrl #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .sysRst(sysRst), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .wrEn(wrEn), .wrCore(wrCore), .wrHigh(wrHigh),
    .countEn(countEn), .privOnly(privOnly), .strobes(strobes)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    tbc_counter #(.HALF_W(HALF_W)) u_cnt (
      .clk(clk), .sysRst(sysRst), .strobe(strobes[i]),
      .wrData(wrData), .value(values[i])
    );
  end

  tbc_readport #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .TB_W(TB_W)) u_rd (
    .clk(clk), .sysRst(sysRst), .rdReq(rdReq), .rdCore(rdCore),
    .rdPriv(rdPriv), .privOnly(privOnly), .values(values),
    .rdValid(rdValid), .rdData(rdData), .rdFault(rdFault)
  );
endmodule

// File: tb/tbase_cluster_bench.sv
module tbase_cluster_bench;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        sysRst;
  logic        countEn;
  logic        wrEn;
  logic [1:0]  wrCore;
  logic        wrHigh;
  logic [31:0] wrData;
  logic        rdReq;
  logic [1:0]  rdCore;
  logic        rdPriv;
  logic        rdValid;
  logic [63:0] rdData;
  logic        rdFault;
  logic        regWr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;

  int nChecks = 0;
  int nErrors = 0;

  logic [63:0] mdl [NC];
  logic        mFreeze;
  logic        mPriv;

  always #4 clk = ~clk;

  tbase_cluster u_tbase_cluster (
    .clk(clk), .sysRst(sysRst), .countEn(countEn),
    .wrEn(wrEn), .wrCore(wrCore), .wrHigh(wrHigh), .wrData(wrData),
    .rdReq(rdReq), .rdCore(rdCore), .rdPriv(rdPriv),
    .rdValid(rdValid), .rdData(rdData), .rdFault(rdFault),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic expFault(input logic req, input logic priv);
    return req && mPriv && !priv;
  endfunction

  task automatic idle();
    wrEn = 0; wrCore = 0; wrHigh = 0; wrData = 0;
    rdReq = 0; rdCore = 0; rdPriv = 0; regWr = 0; regWdata = 0;
  endtask

  // one clock: predict, advance model at the edge, check at negedge
  task automatic tick(input string tag);
    logic        eValid, eFault;
    logic [63:0] eData;
    eValid = rdReq;
    eFault = expFault(rdReq, rdPriv);
    eData  = (rdReq && !eFault) ? mdl[rdCore] : 64'd0;
    @(posedge clk);
    if (sysRst) begin
      for (int c = 0; c < NC; c++) mdl[c] = 64'd0;
      mFreeze = 0; mPriv = 0;
      eValid = 0; eFault = 0; eData = 0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (wrEn && wrCore == 2'(c)) begin
          if (wrHigh) mdl[c][63:32] = wrData;
          else        mdl[c][31:0]  = wrData;
        end else if (!mFreeze) begin
          mdl[c] = mdl[c] + 64'd1;
        end
      end
      if (regWr) begin
        mFreeze = regWdata[0];
        mPriv   = regWdata[1];
      end
    end
    @(negedge clk);
    chk(tag,  "rdValid", {63'd0, rdValid}, {63'd0, eValid});
    chk(tag,  "rdData",  rdData, eData);
    chk(tag,  "rdFault", {63'd0, rdFault}, {63'd0, eFault});
    chk("R7", "countEn", {63'd0, countEn}, {63'd0, !mFreeze});
    chk("R6", "regRdata", {32'd0, regRdata}, {30'd0, mPriv, mFreeze});
  endtask

  task automatic rd(input int core, input logic priv, input string tag);
    idle(); rdReq = 1; rdCore = 2'(core); rdPriv = priv; tick(tag);
  endtask

  task automatic wr(input int core, input logic hi, input logic [31:0] d,
                    input string tag);
    idle(); wrEn = 1; wrCore = 2'(core); wrHigh = hi; wrData = d; tick(tag);
  endtask

  task automatic creg(input logic [31:0] d, input string tag);
    idle(); regWr = 1; regWdata = d; tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++) mdl[c] = 64'd0;
    mFreeze = 0; mPriv = 0;
    idle();
    sysRst = 1;
    repeat (3) tick("R1");
    sysRst = 0;
    idle(); tick("R1");
    rd(0, 0, "R1");          // one increment since reset
    rd(0, 0, "R2");
    rd(3, 1, "R2");
    rd(3, 0, "R2");
    // low half write wins over the increment, then read right after
    wr(1, 0, 32'hFFFF_FFFE, "R3");
    rd(1, 0, "R3");
    rd(1, 0, "R5");          // carry into the upper half
    rd(1, 0, "R5");
    wr(2, 1, 32'hFFFF_FFFF, "R4");
    rd(2, 0, "R4");
    wr(2, 0, 32'hFFFF_FFFF, "R5");
    rd(2, 0, "R5");          // all ones
    rd(2, 0, "R5");          // wrapped to zero
    // freeze, writes still land, then resume
    creg(32'hFFFF_FFFD, "R6");  // upper bits ignored, freeze=1 priv=0
    rd(0, 0, "R7");
    rd(0, 0, "R7");
    wr(0, 1, 32'h1234_5678, "R7");
    rd(0, 0, "R7");
    rd(0, 0, "R7");
    creg(32'd0, "R7");
    rd(0, 0, "R7");
    rd(0, 0, "R7");
    // read restriction
    creg(32'd2, "R6");
    rd(1, 0, "R8");
    idle(); tick("R8");       // fault lasts a single cycle
    rd(1, 1, "R8");
    rd(3, 0, "R8");
    creg(32'd0, "R8");
    rd(1, 0, "R8");
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      idle();
      wrEn   = ($urandom % 4) == 0;
      wrCore = 2'($urandom % NC);
      wrHigh = 1'($urandom % 2);
      wrData = (($urandom % 3) == 0) ? 32'hFFFF_FFFF - ($urandom % 3) : $urandom;
      rdReq  = 1'($urandom % 2);
      rdCore = 2'($urandom % NC);
      rdPriv = 1'($urandom % 2);
      regWr  = ($urandom % 40) == 0;
      regWdata = $urandom;
      tick("R9");
    end
    idle(); tick("R9");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule